// File: doc/BRIEF.md
# Serial Disk Command Packet Engine

This block takes the place of the discrete step, direction and track-zero wires between a disk controller and its drive. Drive control travels as framed bytes over a serial link to a storage host. A byte-wide receive stream delivers frames. The engine checks each frame's CRC, decodes the command and tracks the head position itself. It pulses a strobe for each accepted command and answers every completed frame with a handshake reply on a byte-wide transmit stream.

Payload bytes are passed out one by one as they arrive, for example a track and sector address or sector data. The strobe that follows the frame tells the consumer to commit that payload. A frame that stalls part way is abandoned after a parameterised idle time, so the link can recover from lost bytes.

Top module: `dsk_cmd_engine`

## Requirements
- R1: A frame is received in this order: a command byte, a length byte, that many payload bytes, then the CRC high byte and the CRC low byte. Every good frame with a known command is answered with the acknowledge byte 0x06 as the first reply byte.
- R2: The CRC is CRC-16 with polynomial 0x1021 and start value 0xFFFF. It is computed MSB first over the command, length and payload bytes. On a mismatch the engine replies with the single byte 0x15, pulses no strobe and leaves the head position unchanged.
- R3: The length may be any value from 0 to 255, and 0 is legal. Each payload byte appears on `pl_data` with `pl_valid` high for one cycle, in arrival order, one cycle after it is accepted.
- R4: Command 0x01 (step in) raises the head position by one. At TRACKS-1 the position stays the same but the command is still acknowledged. `stb_step_in` pulses once for each good step-in frame.
- R5: Command 0x02 (step out) lowers the head position by one. At 0 the position stays the same but the command is still acknowledged. `stb_step_out` pulses once for each good step-out frame.
- R6: Command 0x03 (query track zero) is answered with two bytes: 0x06, then 0x01 if the head position is 0 and 0x00 otherwise.
- R7: Command 0x10 (read) and command 0x11 (write) pulse `stb_read` and `stb_write` respectively for one cycle, one cycle after the last CRC byte is accepted. Each is then acknowledged with 0x06.
- R8: A frame with a good CRC but any other command code is answered with the single byte 0x15 and pulses no strobe.
- R9: If no byte arrives for TIMEOUT consecutive cycles in the middle of a frame, the partial frame is dropped without a reply. The next byte is then taken as a command byte. Gaps shorter than TIMEOUT are tolerated.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays stable.
- R11: After reset the head position is 0, and `tx_valid`, `pl_valid` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | rx_data holds a byte this cycle |
| tx_data | output | 8 | Reply byte |
| tx_valid | output | 1 | tx_data holds a reply byte |
| tx_ready | input | 1 | Host side accepts the reply byte |
| pl_data | output | 8 | Payload byte of the current frame |
| pl_valid | output | 1 | pl_data holds a payload byte |
| stb_step_in | output | 1 | Good step-in frame accepted |
| stb_step_out | output | 1 | Good step-out frame accepted |
| stb_read | output | 1 | Good read frame accepted |
| stb_write | output | 1 | Good write frame accepted |
| head_track | output | $clog2(TRACKS) | Tracked head position |
| head_at_zero | output | 1 | Head position is 0 |

## Verification
The assertions assume that the host keeps at most one frame in flight. The host waits for the whole reply before it sends the next frame, so a frame never completes while a reply is still draining. If that happened, the reply unit would ignore the new event. The assertions also assume that step-in and step-out never reach the head tracker in the same cycle, which the decoder guarantees. The bench sends one frame at a time and drains the reply before it moves on. It raises `tx_ready` again after each backpressure test, and it creates stalls only between frame bytes, with gaps either well under or well over the timeout.

// File: rtl/dsk_pkg.sv
package dsk_pkg;

    localparam logic [7:0] CMD_STEP_IN  = 8'h01;
    localparam logic [7:0] CMD_STEP_OUT = 8'h02;
    localparam logic [7:0] CMD_QUERY_T0 = 8'h03;
    localparam logic [7:0] CMD_READ     = 8'h10;
    localparam logic [7:0] CMD_WRITE    = 8'h11;

    localparam logic [7:0] RSP_ACK = 8'h06;
    localparam logic [7:0] RSP_NAK = 8'h15;

    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_INIT = 16'hFFFF;

    typedef enum logic [2:0] {
        PS_CMD,
        PS_LEN,
        PS_DATA,
        PS_CRC_HI,
        PS_CRC_LO
    } parse_st_e;

    // One byte folded into the running CRC, most significant bit first.
    function automatic logic [15:0] crc16_step(input logic [15:0] c_in, input logic [7:0] b);
        logic [15:0] c;
        c = c_in ^ {b, 8'h00};
        for (int i = 0; i < 8; i++) begin
            if (c[15]) c = {c[14:0], 1'b0} ^ CRC_POLY;
            else       c = {c[14:0], 1'b0};
        end
        return c;
    endfunction

endpackage

// File: rtl/dsk_rx_parser.sv
module dsk_rx_parser
    import dsk_pkg::*;
#(
    parameter int TIMEOUT = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] rx_data,
    input  logic       rx_valid,
    output logic [7:0] pl_data,
    output logic       pl_valid,
    output logic       done_ok,
    output logic       done_bad,
    output logic [7:0] frame_cmd
);

    localparam int TOW = $clog2(TIMEOUT + 1);
    localparam logic [TOW-1:0] IDLE_LAST = TOW'(TIMEOUT - 1);

    typedef struct packed {
        parse_st_e      st;
        logic [7:0]     cmd;
        logic [7:0]     remain;
        logic [15:0]    crc;
        logic [7:0]     crc_hi;
        logic [TOW-1:0] idle;
        logic [7:0]     pl_data;
        logic           pl_valid;
        logic           ok;
        logic           bad;
    } prs_t;

    prs_t prs_d, prs_q;

    always_comb begin
        prs_d          = prs_q;
        prs_d.pl_valid = 1'b0;
        prs_d.ok       = 1'b0;
        prs_d.bad      = 1'b0;
        if (rx_valid) begin
            prs_d.idle = '0;
            case (prs_q.st)
                PS_CMD: begin
                    prs_d.cmd = rx_data;
                    prs_d.crc = crc16_step(CRC_INIT, rx_data);
                    prs_d.st  = PS_LEN;
                end
                PS_LEN: begin
                    prs_d.remain = rx_data;
                    prs_d.crc    = crc16_step(prs_q.crc, rx_data);
                    prs_d.st     = (rx_data == 8'd0) ? PS_CRC_HI : PS_DATA;
                end
                PS_DATA: begin
                    prs_d.pl_data  = rx_data;
                    prs_d.pl_valid = 1'b1;
                    prs_d.crc      = crc16_step(prs_q.crc, rx_data);
                    prs_d.remain   = prs_q.remain - 8'd1;
                    if (prs_q.remain == 8'd1) prs_d.st = PS_CRC_HI;
                end
                PS_CRC_HI: begin
                    prs_d.crc_hi = rx_data;
                    prs_d.st     = PS_CRC_LO;
                end
                PS_CRC_LO: begin
                    if ({prs_q.crc_hi, rx_data} == prs_q.crc) prs_d.ok  = 1'b1;
                    else                                      prs_d.bad = 1'b1;
                    prs_d.st = PS_CMD;
                end
                default: prs_d.st = PS_CMD;
            endcase
        end else if (prs_q.st != PS_CMD) begin
            if (prs_q.idle == IDLE_LAST) begin
                prs_d.st   = PS_CMD;
                prs_d.idle = '0;
            end else begin
                prs_d.idle = prs_q.idle + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prs_q <= '{st: PS_CMD, default: '0};
        end else begin
            prs_q <= prs_d;
        end
    end

    assign pl_data   = prs_q.pl_data;
    assign pl_valid  = prs_q.pl_valid;
    assign done_ok   = prs_q.ok;
    assign done_bad  = prs_q.bad;
    assign frame_cmd = prs_q.cmd;

    // R9: a stalled partial frame is abandoned once the idle window runs out
    a_r9_timeout_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (prs_q.st != PS_CMD && !rx_valid && prs_q.idle == IDLE_LAST) |=> prs_q.st == PS_CMD);

    // R9: idle counter never passes the window
    a_r9_idle_bound: assert property (@(posedge clk) disable iff (!rst_n)
        prs_q.idle <= IDLE_LAST);

    // R2: a frame is never both good and bad
    a_r2_verdict_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_ok && done_bad));

    // R3: payload bytes only come out while data bytes are arriving
    a_r3_pl_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && prs_q.st == PS_DATA) |=> pl_valid);

endmodule

// File: rtl/dsk_head_track.sv
module dsk_head_track #(
    parameter int TRACKS = 80
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      step_in,
    input  logic                      step_out,
    output logic [$clog2(TRACKS)-1:0] pos,
    output logic                      at_zero
);

    localparam int TW = $clog2(TRACKS);
    localparam logic [TW-1:0] TOP = TW'(TRACKS - 1);

    logic [TW-1:0] pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (step_in && !step_out && pos_q != TOP)
            pos_d = pos_q + 1'b1;
        else if (step_out && !step_in && pos_q != '0)
            pos_d = pos_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign pos     = pos_q;
    assign at_zero = (pos_q == '0);

    // R4: step in at the top track keeps the position
    a_r4_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
        (step_in && !step_out && pos_q == TOP) |=> pos_q == TOP);

    // R5: step out at track zero keeps the position
    a_r5_sat_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (step_out && !step_in && pos_q == '0) |=> pos_q == '0);

    // R4: position stays within the drive
    a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= TOP);

    // R2: without a step request the position holds
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_in && !step_out) |=> $stable(pos_q));

endmodule

// File: rtl/dsk_tx_reply.sv
module dsk_tx_reply (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] byte0,
    input  logic [7:0] byte1,
    input  logic       two,
    input  logic       tx_ready,
    output logic [7:0] tx_data,
    output logic       tx_valid
);

    typedef struct packed {
        logic [7:0] b0;
        logic [7:0] b1;
        logic [1:0] cnt;
    } rep_t;

    rep_t rep_d, rep_q;

    always_comb begin
        rep_d = rep_q;
        if (rep_q.cnt != 2'd0) begin
            if (tx_ready) begin
                rep_d.b0  = rep_q.b1;
                rep_d.cnt = rep_q.cnt - 2'd1;
            end
        end else if (load) begin
            rep_d.b0  = byte0;
            rep_d.b1  = byte1;
            rep_d.cnt = two ? 2'd2 : 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rep_q <= '0;
        else        rep_q <= rep_d;
    end

    assign tx_valid = (rep_q.cnt != 2'd0);
    assign tx_data  = rep_q.b0;

    // R10: a waiting reply byte is held steady
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

endmodule

// File: rtl/dsk_cmd_engine.sv
module dsk_cmd_engine
    import dsk_pkg::*;
#(
    parameter int TRACKS  = 80,
    parameter int TIMEOUT = 4096
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [7:0]                rx_data,
    input  logic                      rx_valid,
    output logic [7:0]                tx_data,
    output logic                      tx_valid,
    input  logic                      tx_ready,
    output logic [7:0]                pl_data,
    output logic                      pl_valid,
    output logic                      stb_step_in,
    output logic                      stb_step_out,
    output logic                      stb_read,
    output logic                      stb_write,
    output logic [$clog2(TRACKS)-1:0] head_track,
    output logic                      head_at_zero
);

    logic       done_ok, done_bad;
    logic [7:0] frame_cmd;
    logic       known;
    logic       rep_load, rep_two;
    logic [7:0] rep_b0, rep_b1;

    dsk_rx_parser #(.TIMEOUT(TIMEOUT)) u_parser (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .pl_data   (pl_data),
        .pl_valid  (pl_valid),
        .done_ok   (done_ok),
        .done_bad  (done_bad),
        .frame_cmd (frame_cmd)
    );

    always_comb begin
        stb_step_in  = done_ok && (frame_cmd == CMD_STEP_IN);
        stb_step_out = done_ok && (frame_cmd == CMD_STEP_OUT);
        stb_read     = done_ok && (frame_cmd == CMD_READ);
        stb_write    = done_ok && (frame_cmd == CMD_WRITE);
        known        = stb_step_in || stb_step_out || stb_read || stb_write
                    || (frame_cmd == CMD_QUERY_T0);
        rep_load     = done_ok || done_bad;
        rep_b0       = (done_ok && known) ? RSP_ACK : RSP_NAK;
        rep_two      = done_ok && (frame_cmd == CMD_QUERY_T0);
        rep_b1       = {7'd0, head_at_zero};
    end

    dsk_head_track #(.TRACKS(TRACKS)) u_head (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_in  (stb_step_in),
        .step_out (stb_step_out),
        .pos      (head_track),
        .at_zero  (head_at_zero)
    );

    dsk_tx_reply u_reply (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rep_load),
        .byte0    (rep_b0),
        .byte1    (rep_b1),
        .two      (rep_two),
        .tx_ready (tx_ready),
        .tx_data  (tx_data),
        .tx_valid (tx_valid)
    );

    // R8: at most one command strobe per cycle
    a_r8_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stb_step_in, stb_step_out, stb_read, stb_write}));

    // R7: a strobe is always followed by a reply
    a_r7_strobe_replied: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_read || stb_write) && !tx_valid |=> tx_valid);

endmodule

// File: tb/tb_dsk_cmd_engine.sv
`timescale 1ns/1ps
module tb_dsk_cmd_engine;

    localparam int TRACKS  = 4;
    localparam int TIMEOUT = 40;
    localparam int TW      = $clog2(TRACKS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    rx_data = 8'd0;
    logic          rx_valid = 1'b0;
    logic          tx_ready = 1'b1;
    logic [7:0]    tx_data, pl_data;
    logic          tx_valid, pl_valid;
    logic          stb_step_in, stb_step_out, stb_read, stb_write;
    logic [TW-1:0] head_track;
    logic          head_at_zero;

    always #2.5 clk = ~clk;

    dsk_cmd_engine #(.TRACKS(TRACKS), .TIMEOUT(TIMEOUT)) dut (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .pl_data(pl_data), .pl_valid(pl_valid),
        .stb_step_in(stb_step_in), .stb_step_out(stb_step_out),
        .stb_read(stb_read), .stb_write(stb_write),
        .head_track(head_track), .head_at_zero(head_at_zero)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Monitors: only these blocks write the logs
    logic [7:0] tx_log [0:1023];
    logic [7:0] pl_log [0:1023];
    int tx_n = 0, pl_n = 0, n_in = 0, n_out = 0, n_rd = 0, n_wr = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid && tx_ready) begin
                tx_log[tx_n % 1024] <= tx_data;
                tx_n <= tx_n + 1;
            end
            if (pl_valid) begin
                pl_log[pl_n % 1024] <= pl_data;
                pl_n <= pl_n + 1;
            end
            if (stb_step_in)  n_in  <= n_in + 1;
            if (stb_step_out) n_out <= n_out + 1;
            if (stb_read)     n_rd  <= n_rd + 1;
            if (stb_write)    n_wr  <= n_wr + 1;
        end
    end

    int s_tx, s_pl, s_in, s_out, s_rd, s_wr;
    logic [7:0] fbuf [0:255];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c_in, input logic [7:0] b);
        logic [15:0] c;
        logic fb;
        c = c_in;
        for (int i = 7; i >= 0; i--) begin
            fb = c[15] ^ b[i];
            c  = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        end
        return c;
    endfunction

    task automatic send_byte(input logic [7:0] b, input int gap);
        @(negedge clk);
        rx_data  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic snap();
        s_tx = tx_n; s_pl = pl_n; s_in = n_in; s_out = n_out; s_rd = n_rd; s_wr = n_wr;
    endtask

    task automatic send_frame(input logic [7:0] cmd, input int len,
                              input logic [15:0] flip, input int gap);
        logic [15:0] c;
        snap();
        c = ref_crc(16'hFFFF, cmd);
        c = ref_crc(c, 8'(len));
        send_byte(cmd, gap);
        send_byte(8'(len), gap);
        for (int i = 0; i < len; i++) begin
            c = ref_crc(c, fbuf[i]);
            send_byte(fbuf[i], gap);
        end
        c = c ^ flip;
        send_byte(c[15:8], gap);
        send_byte(c[7:0], 0);
        repeat (8) @(negedge clk);
    endtask

    task automatic expect_reply(input int n, input logic [7:0] b0, input logic [7:0] b1,
                                input string tag);
        chk(tx_n - s_tx == n, {tag, " reply count"}, tx_n - s_tx, n);
        if (n >= 1) chk(tx_log[s_tx % 1024] == b0, {tag, " reply byte0"}, tx_log[s_tx % 1024], b0);
        if (n >= 2) chk(tx_log[(s_tx + 1) % 1024] == b1, {tag, " reply byte1"},
                        tx_log[(s_tx + 1) % 1024], b1);
    endtask

    task automatic expect_strobes(input int di, input int dout, input int drd, input int dwr,
                                  input string tag);
        chk(n_in - s_in == di,    {tag, " step-in strobes"},  n_in - s_in, di);
        chk(n_out - s_out == dout, {tag, " step-out strobes"}, n_out - s_out, dout);
        chk(n_rd - s_rd == drd,   {tag, " read strobes"},     n_rd - s_rd, drd);
        chk(n_wr - s_wr == dwr,   {tag, " write strobes"},    n_wr - s_wr, dwr);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int pos;
        int lens [5];
        lens = '{0, 1, 2, 5, 255};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        chk(head_track == 0, "R11 head after reset", head_track, 0);
        chk(!tx_valid && !pl_valid, "R11 tx/pl idle", {tx_valid, pl_valid}, 0);
        chk({stb_step_in, stb_step_out, stb_read, stb_write} == 4'd0, "R11 strobes low",
            {stb_step_in, stb_step_out, stb_read, stb_write}, 0);

        // R6: query at zero
        send_frame(8'h03, 0, 16'h0, 0);
        expect_reply(2, 8'h06, 8'h01, "R6 query at zero");

        // R4 / R1: step in sweep with saturation, query after each
        pos = 0;
        for (int k = 0; k < TRACKS + 2; k++) begin
            send_frame(8'h01, 0, 16'h0, 0);
            pos = (pos < TRACKS - 1) ? pos + 1 : pos;
            expect_reply(1, 8'h06, 8'h00, "R1 R4 step in ack");
            expect_strobes(1, 0, 0, 0, "R4 step in");
            chk(head_track == pos, "R4 head after step in", head_track, pos);
            send_frame(8'h03, 0, 16'h0, 0);
            expect_reply(2, 8'h06, (pos == 0) ? 8'h01 : 8'h00, "R6 query after step in");
        end

        // R5: step out sweep with saturation
        for (int k = 0; k < TRACKS + 2; k++) begin
            send_frame(8'h02, 0, 16'h0, 0);
            pos = (pos > 0) ? pos - 1 : 0;
            expect_reply(1, 8'h06, 8'h00, "R5 step out ack");
            expect_strobes(0, 1, 0, 0, "R5 step out");
            chk(head_track == pos, "R5 head after step out", head_track, pos);
            send_frame(8'h03, 0, 16'h0, 0);
            expect_reply(2, 8'h06, (pos == 0) ? 8'h01 : 8'h00, "R6 query after step out");
        end

        // R3 / R7: read and write with several payload lengths
        for (int li = 0; li < 5; li++) begin
            for (int w = 0; w < 2; w++) begin
                int len;
                bit okp;
                len = lens[li];
                for (int i = 0; i < len; i++) fbuf[i] = 8'((i * 7 + len + w * 3) & 8'hFF);
                send_frame(w ? 8'h11 : 8'h10, len, 16'h0, 0);
                expect_reply(1, 8'h06, 8'h00, "R7 read/write ack");
                expect_strobes(0, 0, w ? 0 : 1, w ? 1 : 0, "R7 read/write");
                chk(pl_n - s_pl == len, "R3 payload count", pl_n - s_pl, len);
                okp = 1'b1;
                for (int i = 0; i < len; i++)
                    if (pl_log[(s_pl + i) % 1024] != fbuf[i]) okp = 1'b0;
                chk(okp, "R3 payload bytes in order", okp, 1);
            end
        end

        // R2: every single-bit CRC corruption is refused
        for (int k = 0; k < 16; k++) begin
            fbuf[0] = 8'h12; fbuf[1] = 8'h34; fbuf[2] = 8'h56;
            send_frame(8'h11, 3, 16'(1 << k), 0);
            expect_reply(1, 8'h15, 8'h00, "R2 bad crc nak");
            expect_strobes(0, 0, 0, 0, "R2 bad crc");
        end
        send_frame(8'h01, 0, 16'h8000, 0);
        expect_reply(1, 8'h15, 8'h00, "R2 bad crc step");
        chk(head_track == 0, "R2 head unchanged on bad crc", head_track, 0);

        // R8: unknown command codes
        for (int c = 0; c < 32; c++) begin
            if (c != 1 && c != 2 && c != 3 && c != 16 && c != 17) begin
                fbuf[0] = 8'hA5;
                send_frame(8'(c), 1, 16'h0, 0);
                expect_reply(1, 8'h15, 8'h00, "R8 unknown nak");
                expect_strobes(0, 0, 0, 0, "R8 unknown");
            end
        end

        // R9: stalled partial frame is dropped, then a fresh frame works
        snap();
        send_byte(8'h10, 0);
        send_byte(8'h02, 0);
        send_byte(8'hAA, TIMEOUT + 20);
        chk(tx_n - s_tx == 0, "R9 no reply to stalled frame", tx_n - s_tx, 0);
        send_frame(8'h01, 0, 16'h0, 0);
        expect_reply(1, 8'h06, 8'h00, "R9 frame after timeout");
        chk(head_track == 1, "R9 head after recovery", head_track, 1);
        // R9: gaps under the window are tolerated
        send_frame(8'h02, 0, 16'h0, TIMEOUT - 10);
        expect_reply(1, 8'h06, 8'h00, "R9 slow frame");
        chk(head_track == 0, "R9 head after slow frame", head_track, 0);

        // R10: backpressure on the reply
        tx_ready = 1'b0;
        send_frame(8'h03, 0, 16'h0, 0);
        chk(tx_valid && tx_data == 8'h06, "R10 reply waiting", {tx_valid, tx_data}, 9'h106);
        repeat (10) @(negedge clk);
        chk(tx_valid && tx_data == 8'h06, "R10 reply held", {tx_valid, tx_data}, 9'h106);
        tx_ready = 1'b1;
        repeat (6) @(negedge clk);
        expect_reply(2, 8'h06, 8'h01, "R10 reply after release");
        chk(!tx_valid, "R10 reply drained", tx_valid, 0);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule